// File: doc/BRIEF.md
# USB High-Speed Electrical Test-Mode Sequencer

This block runs the four electrical compliance test modes of a high-speed USB device port. Firmware, or the control-endpoint logic, hands it a selector code on a strobe while it handles a test-mode feature request. The code is held as pending and only becomes the active mode when the status stage of that request finishes. Once a mode is active it stays active until reset. Later requests have no effect on it.

In the two line-level modes the block forces a steady J or a steady K onto the line. In the NAK mode token reception keeps working, and every valid IN token addressed to this device is answered with a NAK handshake request. In the packet mode a fixed test packet is streamed byte by byte to the transmitter, with a byte handshake on each byte. Copies of the packet are separated by a fixed gap, during which the line is held at SE0. This repeats with no end. The packet contents come from a parameter, so the block can be built for any table.

Top module: `usb_tmode_seq`

## Requirements
- R1: After reset no mode is active: `line_ovr` is 0 (no override), `nak_req` is 0 and `pkt_valid` is 0.
- R2: Selector codes decode as 1 = steady J, 2 = steady K, 3 = NAK mode, 4 = packet mode. A strobe with any other code is ignored and leaves every output unchanged, even after a later status completion.
- R3: A valid code takes effect on the first `status_done` pulse after its strobe. Outputs change on the clock edge that samples `status_done`, and until then the outputs stay as they were.
- R4: Once a mode is active, further strobes and status completions have no effect until reset.
- R5: In steady J mode `line_ovr` = 2'b01 on every cycle. In steady K mode `line_ovr` = 2'b10 on every cycle.
- R6: In NAK mode, a cycle with `tok_valid`, `tok_in` and `tok_match` all high raises `nak_req` for exactly the following cycle. A token that is not IN, does not match, or is not valid raises nothing.
- R7: Outside NAK mode `nak_req` stays 0 whatever tokens arrive.
- R8: In packet mode `pkt_valid` is high while a packet is being sent. `pkt_data` shows ROM byte i, where byte i is bits [8i+7:8i] of `PKT_ROM`, starting at byte 0. Each byte is held until `sym_ready` is sampled high. `pkt_last` is high with the final byte.
- R9: After the final byte is accepted, `pkt_valid` is low for exactly `GAP_BYTES` cycles, and `line_ovr` = 2'b11 (hold SE0) during that time. Then byte 0 follows again, and this repeats indefinitely. `GAP_BYTES` x 8 bit times must lie between 8 and 192.
- R10: `line_ovr` is 2'b00 (no override) in NAK mode, and also in packet mode while bytes are being sent.
- R11: Reset leaves any active mode and returns to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one byte time per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_valid | input | 1 | Strobe for the selector code |
| sel_code | input | SEL_W | Test selector code |
| status_done | input | 1 | Status stage of the request completed |
| tok_valid | input | 1 | Decoded token PID is valid |
| tok_in | input | 1 | Token is an IN token |
| tok_match | input | 1 | Token address and endpoint match this device |
| sym_ready | input | 1 | Transmitter accepts the presented byte |
| line_ovr | output | 2 | Line override: 00 none, 01 J, 10 K, 11 SE0 |
| nak_req | output | 1 | Request to send a NAK handshake |
| pkt_valid | output | 1 | Test-packet byte is presented |
| pkt_data | output | 8 | Test-packet byte |
| pkt_last | output | 1 | Presented byte is the last of the packet |

## Verification
Selector codes outside 1 to 4 are sent next to valid ones. This separates a decoder that rejects bad codes from one that drops them into some mode. The NAK mode is driven with matched IN tokens, non-IN tokens, unmatched tokens and invalid tokens, including back-to-back IN tokens. These show that the handshake depends on all three qualifiers and lasts exactly one cycle per token. The packet stream is first held with `sym_ready` low and then run with it high over two full copies, so a stalled byte, a misordered byte, an off-by-one gap or a missing restart each produce a mismatch.

// File: rtl/tmode_pkg.sv
package tmode_pkg;

    typedef enum logic [2:0] {
        TM_NONE   = 3'd0,
        TM_J      = 3'd1,
        TM_K      = 3'd2,
        TM_SE0NAK = 3'd3,
        TM_PKT    = 3'd4
    } tmode_e;

    typedef enum logic [1:0] {
        LN_PASS = 2'b00,
        LN_J    = 2'b01,
        LN_K    = 2'b10,
        LN_SE0  = 2'b11
    } line_e;

endpackage

// File: rtl/tmode_sel.sv
// Holds a pending selector and commits it on status completion; sticky until reset.
module tmode_sel
    import tmode_pkg::*;
#(
    parameter int SEL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_valid,
    input  logic [SEL_W-1:0] sel_code,
    input  logic             status_done,
    output tmode_e           mode
);

    typedef struct packed {
        tmode_e pend;
        tmode_e mode;
    } sel_st_t;

    sel_st_t st_d, st_q;
    tmode_e  dec;

    always_comb begin
        unique case (sel_code)
            SEL_W'(1): dec = TM_J;
            SEL_W'(2): dec = TM_K;
            SEL_W'(3): dec = TM_SE0NAK;
            SEL_W'(4): dec = TM_PKT;
            default:   dec = TM_NONE;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (st_q.mode == TM_NONE) begin
            if (status_done && (st_q.pend != TM_NONE)) begin
                st_d.mode = st_q.pend;
                st_d.pend = TM_NONE;
            end else if (sel_valid && (dec != TM_NONE)) begin
                st_d.pend = dec;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{pend: TM_NONE, mode: TM_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode = st_q.mode;

endmodule

// File: rtl/tmode_nak.sv
// Registers a NAK request for each qualified IN token while enabled.
module tmode_nak (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tok_valid,
    input  logic tok_in,
    input  logic tok_match,
    output logic nak_req
);

    typedef struct packed {
        logic nak;
    } nak_st_t;

    nak_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.nak = en && tok_valid && tok_in && tok_match;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{nak: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign nak_req = st_q.nak;

endmodule

// File: rtl/tmode_pktgen.sv
// Streams the packet ROM byte by byte, then idles GAP_BYTES cycles, forever.
module tmode_pktgen #(
    parameter int                   PKT_LEN   = 8,
    parameter int                   GAP_BYTES = 4,
    parameter logic [PKT_LEN*8-1:0] PKT_ROM   = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       sym_ready,
    output logic       pkt_valid,
    output logic [7:0] pkt_data,
    output logic       pkt_last,
    output logic       in_gap
);

    localparam int IW = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1;
    localparam int CW = $clog2(GAP_BYTES + 1);
    localparam logic [IW-1:0] LAST_IDX = IW'(PKT_LEN - 1);
    localparam logic [CW-1:0] GAP_LOAD = CW'(GAP_BYTES - 1);

    typedef struct packed {
        logic          gap;
        logic [IW-1:0] idx;
        logic [CW-1:0] cnt;
    } pg_st_t;

    pg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            if (!st_q.gap) begin
                if (sym_ready) begin
                    if (st_q.idx == LAST_IDX) begin
                        st_d.idx = '0;
                        st_d.gap = 1'b1;
                        st_d.cnt = GAP_LOAD;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end
            end else if (st_q.cnt == '0) begin
                st_d.gap = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{gap: 1'b0, idx: '0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pkt_valid = en && !st_q.gap;
    assign pkt_data  = pkt_valid ? PKT_ROM[st_q.idx*8 +: 8] : 8'h00;
    assign pkt_last  = pkt_valid && (st_q.idx == LAST_IDX);
    assign in_gap    = en && st_q.gap;

endmodule

// File: rtl/usb_tmode_seq.sv
module usb_tmode_seq
    import tmode_pkg::*;
#(
    parameter int                   SEL_W     = 8,
    parameter int                   PKT_LEN   = 8,
    parameter int                   GAP_BYTES = 4,
    parameter logic [PKT_LEN*8-1:0] PKT_ROM   = 64'hFEFF_AAAA_5500_00C3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_valid,
    input  logic [SEL_W-1:0] sel_code,
    input  logic             status_done,
    input  logic             tok_valid,
    input  logic             tok_in,
    input  logic             tok_match,
    input  logic             sym_ready,
    output logic [1:0]       line_ovr,
    output logic             nak_req,
    output logic             pkt_valid,
    output logic [7:0]       pkt_data,
    output logic             pkt_last
);

    tmode_e mode;
    logic   in_gap;
    line_e  ln;

    tmode_sel #(.SEL_W(SEL_W)) u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_valid   (sel_valid),
        .sel_code    (sel_code),
        .status_done (status_done),
        .mode        (mode)
    );

    tmode_nak u_nak (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (mode == TM_SE0NAK),
        .tok_valid (tok_valid),
        .tok_in    (tok_in),
        .tok_match (tok_match),
        .nak_req   (nak_req)
    );

    tmode_pktgen #(
        .PKT_LEN   (PKT_LEN),
        .GAP_BYTES (GAP_BYTES),
        .PKT_ROM   (PKT_ROM)
    ) u_pkt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (mode == TM_PKT),
        .sym_ready (sym_ready),
        .pkt_valid (pkt_valid),
        .pkt_data  (pkt_data),
        .pkt_last  (pkt_last),
        .in_gap    (in_gap)
    );

    always_comb begin
        unique case (mode)
            TM_J:    ln = LN_J;
            TM_K:    ln = LN_K;
            TM_PKT:  ln = in_gap ? LN_SE0 : LN_PASS;
            default: ln = LN_PASS;
        endcase
    end

    assign line_ovr = ln;

endmodule

// File: rtl/tmode_seq_chk.sv
module tmode_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tok_valid,
    input logic       tok_in,
    input logic       tok_match,
    input logic       sym_ready,
    input logic [1:0] line_ovr,
    input logic       nak_req,
    input logic       pkt_valid,
    input logic [7:0] pkt_data,
    input logic       pkt_last
);

    assert_j_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_ovr == 2'b01) |=> (line_ovr == 2'b01));

    assert_k_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_ovr == 2'b10) |=> (line_ovr == 2'b10));

    assert_nak_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        nak_req |-> $past(tok_valid && tok_in && tok_match));

    assert_nak_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        nak_req |-> (line_ovr == 2'b00) && !pkt_valid);

    assert_byte_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !sym_ready) |=> pkt_valid && $stable(pkt_data));

    assert_gap_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_last && sym_ready) |=> !pkt_valid && (line_ovr == 2'b11));

    assert_no_ovr_sending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (line_ovr == 2'b00));

endmodule

bind usb_tmode_seq tmode_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_valid (tok_valid),
    .tok_in    (tok_in),
    .tok_match (tok_match),
    .sym_ready (sym_ready),
    .line_ovr  (line_ovr),
    .nak_req   (nak_req),
    .pkt_valid (pkt_valid),
    .pkt_data  (pkt_data),
    .pkt_last  (pkt_last)
);

// File: tb/usb_tmode_seq_tb.sv
module usb_tmode_seq_tb;

    localparam int          LEN = 6;
    localparam int          GAP = 3;
    localparam logic [47:0] ROM = 48'h3C_A5_0F_F0_5A_C3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sel_valid, status_done, tok_valid, tok_in, tok_match, sym_ready;
    logic [7:0] sel_code;
    logic [1:0] line_ovr;
    logic       nak_req, pkt_valid, pkt_last;
    logic [7:0] pkt_data;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    usb_tmode_seq #(.SEL_W(8), .PKT_LEN(LEN), .GAP_BYTES(GAP), .PKT_ROM(ROM)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_code(sel_code),
        .status_done(status_done), .tok_valid(tok_valid), .tok_in(tok_in),
        .tok_match(tok_match), .sym_ready(sym_ready), .line_ovr(line_ovr),
        .nak_req(nak_req), .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_last(pkt_last)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_outs(input string req);
        check(req, {30'd0, line_ovr}, 32'd0);
        check(req, {31'd0, nak_req}, 32'd0);
        check(req, {31'd0, pkt_valid}, 32'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sel_valid = 0; sel_code = 0; status_done = 0;
        tok_valid = 0; tok_in = 0; tok_match = 0; sym_ready = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic strobe(input logic [7:0] code);
        sel_valid = 1'b1; sel_code = code;
        @(negedge clk);
        sel_valid = 1'b0; sel_code = 0;
    endtask

    task automatic status();
        status_done = 1'b1;
        @(negedge clk);
        status_done = 1'b0;
    endtask

    task automatic token(input logic v, input logic i, input logic m);
        tok_valid = v; tok_in = i; tok_match = m;
        @(negedge clk);
        tok_valid = 0; tok_in = 0; tok_match = 0;
    endtask

    task automatic t_reset();
        do_reset();
        idle_outs("R1");
    endtask

    task automatic t_bad_codes();
        do_reset();
        strobe(8'd0); status(); idle_outs("R2 code0");
        strobe(8'd5); status(); idle_outs("R2 code5");
        strobe(8'hFF); status(); idle_outs("R2 codeFF");
        token(1, 1, 1);
        check("R7 no mode", {31'd0, nak_req}, 32'd0);
    endtask

    task automatic t_jmode();
        do_reset();
        strobe(8'd1);
        @(negedge clk);
        check("R3 before status", {30'd0, line_ovr}, 32'd0);
        status();
        check("R5 J", {30'd0, line_ovr}, 32'd1);
        strobe(8'd2); status();
        check("R4 sticky", {30'd0, line_ovr}, 32'd1);
        token(1, 1, 1);
        check("R7 J mode", {31'd0, nak_req}, 32'd0);
        repeat (5) @(negedge clk);
        check("R5 J held", {30'd0, line_ovr}, 32'd1);
        do_reset();
        idle_outs("R11");
    endtask

    task automatic t_kmode();
        do_reset();
        strobe(8'd2); status();
        check("R5 K", {30'd0, line_ovr}, 32'd2);
        check("R7 K mode pkt", {31'd0, pkt_valid}, 32'd0);
    endtask

    task automatic t_nak();
        do_reset();
        strobe(8'd3); status();
        check("R10 nak mode", {30'd0, line_ovr}, 32'd0);
        token(1, 1, 1);
        check("R6 IN", {31'd0, nak_req}, 32'd1);
        @(negedge clk);
        check("R6 one cycle", {31'd0, nak_req}, 32'd0);
        token(1, 0, 1);
        check("R6 not IN", {31'd0, nak_req}, 32'd0);
        token(1, 1, 0);
        check("R6 no match", {31'd0, nak_req}, 32'd0);
        token(0, 1, 1);
        check("R6 invalid", {31'd0, nak_req}, 32'd0);
        tok_valid = 1; tok_in = 1; tok_match = 1;
        @(negedge clk);
        check("R6 b2b first", {31'd0, nak_req}, 32'd1);
        @(negedge clk);
        tok_valid = 0; tok_in = 0; tok_match = 0;
        check("R6 b2b second", {31'd0, nak_req}, 32'd1);
        strobe(8'd1); status();
        check("R4 nak sticky", {30'd0, line_ovr}, 32'd0);
    endtask

    task automatic t_pkt();
        do_reset();
        sym_ready = 1'b0;
        strobe(8'd4); status();
        for (int s = 0; s < 3; s++) begin
            check("R8 stall valid", {31'd0, pkt_valid}, 32'd1);
            check("R8 stall data", {24'd0, pkt_data}, {24'd0, ROM[7:0]});
            @(negedge clk);
        end
        sym_ready = 1'b1;
        for (int c = 0; c < 2; c++) begin
            for (int i = 0; i < LEN; i++) begin
                check("R8 valid", {31'd0, pkt_valid}, 32'd1);
                check("R8 data", {24'd0, pkt_data}, {24'd0, ROM[i*8 +: 8]});
                check("R8 last", {31'd0, pkt_last}, {31'd0, (i == LEN - 1)});
                check("R10 sending", {30'd0, line_ovr}, 32'd0);
                @(negedge clk);
            end
            for (int g = 0; g < GAP; g++) begin
                check("R9 gap", {31'd0, pkt_valid}, 32'd0);
                check("R9 SE0", {30'd0, line_ovr}, 32'd3);
                @(negedge clk);
            end
        end
        check("R9 restart", {24'd0, pkt_data}, {24'd0, ROM[7:0]});
        sym_ready = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; sel_valid = 0; sel_code = 0; status_done = 0;
        tok_valid = 0; tok_in = 0; tok_match = 0; sym_ready = 0;
        t_reset();
        t_bad_codes();
        t_jmode();
        t_kmode();
        t_nak();
        t_pkt();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule